// File: doc/BRIEF.md
# Interval-Timed SPI Master

This block is a SPI master with a small four-word register interface. Software writes the transmit word to the data register and the block shifts out between 1 and 16 bits, MSB first, while collecting the same number of bits from the serial input. The received word is kept right-aligned for software to read back. The serial clock is a fixed division of the system clock. SCLK idles low, MOSI changes on the falling edge and MISO is sampled on the rising edge.

In interval mode the block repeats the transfer by itself. When a transfer ends, a timer is loaded with the programmed interval count and counts down once per bit-clock period. When it expires, the transfer flag is set again and the same transmit word goes out. A loopback switch feeds the outgoing serial data back into the receive path, so the read-back equals the written word cut to the transfer length.

Register map (addr): 0 data, 1 control, 2 interval control, 3 status.

Top module: `spi_interval_master`

## Requirements
- R1: After reset all four registers read 0, cs_n is high and sclk and mosi are low.
- R2: A write to the data register, made while control bit 15 (master) is 1 and no transfer is pending or running, starts a transfer of control[3:0]+1 bits. cs_n stays low for exactly that many bit periods of 2*HALF clocks. MOSI carries the low bits of the written word, MSB first.
- R3: After a transfer the data register (addr 0) reads the received bits right-aligned, with every bit above the transfer length read as 0.
- R4: Status (addr 3) bit 13 reads 1 from the starting write until the transfer ends. Status bit 14 and the irq output become 1 when a transfer ends. Reading the data register clears bit 14 and irq.
- R5: With interval control bit 14 (loopback) set, the received word equals the transmitted word masked to the length, and MISO has no effect.
- R6: A transfer that ends while the previous received word is still unread sets status bit 15. The bit stays 1 through data reads and other status writes, and clears only on a status write with bit 15 = 1.
- R7: With interval control bit 13 (interval enable) set in master mode, cs_n stays high for exactly count+1 bit periods after each transfer, where count is interval control bits 12:0. The same word is then sent again, and status bit 13 reads 1 during that automatic transfer.
- R8: An interval count of 0 starts the next transfer one bit period after the previous one ends.
- R9: Clearing interval enable stops all automatic transfers: after the current transfer ends, cs_n stays high.
- R10: With the master bit at 0, interval enable has no effect and a data write starts nothing: cs_n stays high and status bit 13 stays 0.
- R11: Unused register bits read 0. Control reads back master at bit 15 and length-1 at bits 3:0. Interval control bit 15 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (read side effects) |
| addr | input | 2 | Register select |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the selected register (combinational) |
| irq | output | 1 | Interrupt request, mirrors status bit 14 |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Active-low chip select |
| miso | input | 1 | Serial data in |

## Verification
Corrupted counter state shows up at once on the serial side. A wrong bit counter changes how long cs_n stays low within the same transfer. A wrong interval timer changes the high gap before the next cs_n fall, and each gap is timed to the nanosecond. A broken shift register shows in the captured MOSI word, or in the data read back after the same transfer completes. Sticky-flag faults appear at the next status read, because the sets and clears are provoked and then read in direct sequence.

// File: rtl/spi_interval_master.sv
`timescale 1ns/1ps
module spi_interval_master #(
  parameter int HALF = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [1:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        irq,
  output logic        sclk,
  output logic        mosi,
  output logic        cs_n,
  input  logic        miso
);
  localparam int DW = 16;
  localparam int LW = $clog2(DW);
  localparam int CW = 13;
  localparam int PW = (HALF > 1) ? $clog2(HALF) : 1;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_WAIT} st_t;
  st_t state;

  logic [PW-1:0] pre;
  logic          half;
  logic          mst, lpbk, ivl_en, ovr, irq_f, xch, full;
  logic [LW-1:0] len_m1, bit_idx;
  logic [CW-1:0] ivl_cnt, timer;
  logic [DW-1:0] tx_q, rx_q, sh_tx, sh_rx;

  wire tick    = (pre == PW'(HALF - 1));
  wire per_end = tick & half;
  wire mid     = tick & ~half;
  wire ivl_act = mst & ivl_en;
  wire rx_bit  = lpbk ? mosi : miso;
  wire data_rd = rd_en & (addr == 2'd0);

  assign mosi = ~cs_n & sh_tx[DW-1];
  assign irq  = irq_f;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pre  <= '0;
      half <= 1'b0;
    end else if (tick) begin
      pre  <= '0;
      half <= ~half;
    end else begin
      pre  <= pre + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE;
      mst <= 1'b0; len_m1 <= '0;
      lpbk <= 1'b0; ivl_en <= 1'b0; ivl_cnt <= '0;
      ovr <= 1'b0; irq_f <= 1'b0; xch <= 1'b0; full <= 1'b0;
      tx_q <= '0; rx_q <= '0; sh_tx <= '0; sh_rx <= '0;
      bit_idx <= '0; timer <= '0;
      sclk <= 1'b0; cs_n <= 1'b1;
    end else begin
      if (wr_en)
        case (addr)
          2'd0: begin
            tx_q <= wdata;
            if (state == S_IDLE && mst && !xch) xch <= 1'b1;
          end
          2'd1: begin
            mst    <= wdata[15];
            len_m1 <= wdata[LW-1:0];
          end
          2'd2: begin
            lpbk    <= wdata[14];
            ivl_en  <= wdata[13];
            ivl_cnt <= wdata[CW-1:0];
          end
          default: if (wdata[15]) ovr <= 1'b0;
        endcase
      if (data_rd) begin
        irq_f <= 1'b0;
        full  <= 1'b0;
      end

      case (state)
        S_IDLE: begin
          if (xch && !mst) xch <= 1'b0;
          else if (xch && per_end) begin
            state   <= S_RUN;
            cs_n    <= 1'b0;
            sh_tx   <= tx_q << (LW'(DW - 1) - len_m1);
            sh_rx   <= '0;
            bit_idx <= len_m1;
          end
        end
        S_RUN: begin
          if (mid) begin
            sclk  <= 1'b1;
            sh_rx <= {sh_rx[DW-2:0], rx_bit};
          end
          if (per_end) begin
            sclk <= 1'b0;
            if (bit_idx == '0) begin
              cs_n  <= 1'b1;
              xch   <= 1'b0;
              rx_q  <= sh_rx;
              irq_f <= 1'b1;
              full  <= 1'b1;
              if (full && !data_rd) ovr <= 1'b1;
              if (ivl_act) begin
                timer <= ivl_cnt;
                state <= S_WAIT;
              end else begin
                state <= S_IDLE;
              end
            end else begin
              bit_idx <= bit_idx - 1'b1;
              sh_tx   <= sh_tx << 1;
            end
          end
        end
        default: begin
          if (!ivl_act) state <= S_IDLE;
          else if (per_end) begin
            if (timer == '0) begin
              xch     <= 1'b1;
              state   <= S_RUN;
              cs_n    <= 1'b0;
              sh_tx   <= tx_q << (LW'(DW - 1) - len_m1);
              sh_rx   <= '0;
              bit_idx <= len_m1;
            end else begin
              timer <= timer - 1'b1;
            end
          end
        end
      endcase
    end

  always_comb begin
    rdata = '0;
    case (addr)
      2'd0: rdata = rx_q;
      2'd1: begin
        rdata[15]     = mst;
        rdata[LW-1:0] = len_m1;
      end
      2'd2: rdata = {1'b0, lpbk, ivl_en, ivl_cnt};
      default: rdata[15:13] = {ovr, irq_f, xch};
    endcase
  end

  AST_SCLK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);  // R2
  AST_AUTO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT && ivl_act && per_end && timer == '0) |=> (xch && !cs_n));  // R7
  AST_WAIT_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT && !ivl_act) |=> (state == S_IDLE && cs_n));  // R9
  AST_SLAVE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && !mst) |=> cs_n);  // R10
  AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !(wr_en && addr == 2'd3 && wdata[15])) |=> ovr);  // R6
endmodule

// File: tb/tb_spi_interval_master.sv
`timescale 1ns/1ps
module tb_spi_interval_master;
  localparam int HALF = 2;
  localparam int TBIT = 2 * HALF * 20;

  logic clk = 1'b0, rst_n, wr_en, rd_en, miso = 1'b0;
  logic [1:0] addr;
  logic [15:0] wdata, rdata;
  logic irq, sclk, mosi, cs_n;

  spi_interval_master #(.HALF(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .sclk(sclk), .mosi(mosi),
    .cs_n(cs_n), .miso(miso));

  always #10 clk = ~clk;

  typedef struct { logic [15:0] w; int n; } exp_t;
  exp_t q[$];
  int n_cmp = 0, n_bad = 0, cyc = 0;
  int cur_len = 8, nb = 0, falls = 0, rises = 0;
  logic [15:0] slv_word = '0, cap = '0;
  time t_fall = 0, t_rise = 0, last_gap = 0;

  function automatic logic [15:0] msk(int n);
    return (n >= 16) ? 16'hFFFF : ((16'h1 << n) - 16'h1);
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      finish_run();
    end
  end

  // monitor: capture MOSI and time chip select
  always @(posedge sclk) if (!cs_n) begin cap = {cap[14:0], mosi}; nb++; end
  always @(negedge cs_n) begin
    last_gap = $time - t_rise;
    t_fall = $time;
    falls++;
  end
  always @(negedge cs_n or negedge sclk)
    if (!cs_n) miso = (cur_len - 1 - nb >= 0) ? slv_word[cur_len - 1 - nb] : 1'b0;
  always @(posedge cs_n) if (nb > 0) begin
    exp_t e;
    t_rise = $time;
    rises++;
    if (q.size() == 0) chk(0, "R2 unexpected transfer", cap, 0);
    else begin
      e = q.pop_front();
      chk(nb == e.n, "R2 bit count", nb, e.n);
      chk((cap & msk(e.n)) == e.w, "R2 mosi word", cap & msk(e.n), e.w);
      chk((t_rise - t_fall) == e.n * TBIT, "R2 cs low time", t_rise - t_fall, e.n * TBIT);
    end
    nb = 0; cap = '0;
  end

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d, input bit fx = 0);
    @(negedge clk); addr = a; rd_en = fx; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic push(logic [15:0] tx, int n);
    q.push_back('{tx & msk(n), n});
  endtask

  task automatic wait_done();
    logic [15:0] s;
    for (int i = 0; i < 400; i++) begin
      rd(2'd3, s);
      if (!s[13] && cs_n) break;
    end
  endtask

  task automatic xfer(int n, logic [15:0] tx, logic [15:0] sw, bit take, logic [15:0] exp_rx);
    logic [15:0] s, d;
    wr(2'd1, 16'h8000 | 16'(n - 1));
    cur_len = n; slv_word = sw;
    push(tx, n);
    wr(2'd0, tx);
    rd(2'd3, s);
    chk(s[13] == 1'b1, "R4 xch while busy", s, 16'h2000);
    wait_done();
    rd(2'd3, s);
    chk(s[14] && irq, "R4 irq on completion", {s[14], irq}, 2'b11);
    if (take) begin
      rd(2'd0, d, 1);
      chk(d == exp_rx, "R3 received word", d, exp_rx);
      rd(2'd3, s);
      chk(!s[14] && !irq, "R4 irq cleared by data read", {s[14], irq}, 2'b00);
    end
  endtask

  initial begin
    logic [15:0] d;
    int f0, r0;
    rst_n = 0; wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk(d == 16'h0, "R1 register reset", d, 0);
    end
    chk(cs_n && !sclk && !mosi, "R1 pins idle", {cs_n, sclk, mosi}, 3'b100);

    xfer(8,  16'hA53C, 16'h0096, 1, 16'h0096);
    xfer(16, 16'h1234, 16'hBEEF, 1, 16'hBEEF);
    xfer(1,  16'h8001, 16'hFFFF, 1, 16'h0001);
    xfer(5,  16'hFFF3, 16'hFFE5, 1, 16'h0005);

    wr(2'd2, 16'h4000);
    xfer(12, 16'hF3C9, 16'h0C36, 1, 16'h03C9);  // R5 loopback ignores miso
    wr(2'd2, 16'h0000);

    xfer(8, 16'h0F0F, 16'h0055, 0, 16'h0);
    xfer(8, 16'h00F0, 16'h00AA, 0, 16'h0);
    rd(2'd3, d); chk(d[15], "R6 overrun set", d, 16'hC000);
    rd(2'd0, d, 1); chk(d == 16'h00AA, "R6 latest word kept", d, 16'h00AA);
    rd(2'd3, d); chk(d[15] && !d[14], "R6 overrun survives data read", d, 16'h8000);
    wr(2'd3, 16'h4000);
    rd(2'd3, d); chk(d[15], "R6 overrun survives other write", d, 16'h8000);
    wr(2'd3, 16'h8000);
    rd(2'd3, d); chk(d == 16'h0, "R6 overrun cleared", d, 0);

    wr(2'd1, 16'h7FF5);
    rd(2'd1, d); chk(d == 16'h0005, "R11 control readback", d, 16'h0005);
    wr(2'd2, 16'hFFFF);
    rd(2'd2, d); chk(d == 16'h7FFF, "R11 interval readback", d, 16'h7FFF);
    wr(2'd2, 16'h0000);

    // R7 interval count 3
    wr(2'd1, 16'h8007); cur_len = 8; slv_word = 16'h0011;
    wr(2'd2, 16'h2003);
    f0 = falls; r0 = rises;
    repeat (3) push(16'h00C7, 8);
    wr(2'd0, 16'h00C7);
    wait (falls == f0 + 2);
    chk(last_gap == 4 * TBIT, "R7 interval gap", last_gap, 4 * TBIT);
    rd(2'd3, d); chk(d[13], "R7 xch on auto restart", d, 16'h2000);
    wait (falls == f0 + 3);
    chk(last_gap == 4 * TBIT, "R7 interval gap 2", last_gap, 4 * TBIT);
    wait (rises == r0 + 3);
    wr(2'd2, 16'h0003);
    repeat (120) @(negedge clk);
    chk(falls == f0 + 3, "R9 stop in wait", falls - f0, 3);
    rd(2'd0, d, 1); wr(2'd3, 16'h8000);

    // R8 interval count 0
    wr(2'd2, 16'h2000);
    f0 = falls; r0 = rises;
    repeat (3) push(16'h005A, 8);
    wr(2'd0, 16'h005A);
    wait (falls == f0 + 2);
    chk(last_gap == TBIT, "R8 zero-count gap", last_gap, TBIT);
    wait (falls == f0 + 3);
    wr(2'd2, 16'h0000);
    wait (rises == r0 + 3);
    repeat (60) @(negedge clk);
    chk(falls == f0 + 3, "R9 stop during transfer", falls - f0, 3);
    rd(2'd0, d, 1); wr(2'd3, 16'h8000);

    // R10 slave mode
    wr(2'd1, 16'h0007); wr(2'd2, 16'h2002);
    f0 = falls;
    wr(2'd0, 16'h1111);
    repeat (100) @(negedge clk);
    chk(falls == f0 && cs_n, "R10 no transfer", falls - f0, 0);
    rd(2'd3, d); chk(!d[13], "R10 xch stays clear", d, 0);

    chk(q.size() == 0, "R2 all transfers seen", q.size(), 0);
    finish_run();
  end
endmodule